// File: doc/BRIEF.md
# First-Order All-Digital Phase-Locked Loop Core

This block holds every piece of a first-order digital phase-locked loop except the divide-by-N counter. Two phase detectors compare a reference signal with a comparison signal that comes back from an external divide-by-N counter. One detector is a plain exclusive-OR. The other is edge-controlled: a rising reference edge sets it and a rising comparison edge clears it. The integrator wires whichever detector output it wants back to the direction input. That input steers an up/down counter whose length is chosen at run time by a 4-bit code. When the counter wraps it emits a carry or a borrow pulse.

The carry and borrow pulses act on an increment/decrement circuit. With no correction, this circuit toggles its output on every I/D enable strobe, so the output runs at half the I/D strobe rate. A carry inserts one extra half-cycle into that output, and a borrow removes one. The divide-by-N counter outside the block therefore sees a frequency that is nudged up or down. The loop centre frequency is the I/D strobe rate divided by 2N.

Everything runs on one system clock. The "K clock" and the "I/D clock" are single-cycle enable strobes on that clock. A narrow modulus gives fast lock and wide capture. A long modulus gives slow lock and a narrow bandwidth. The code may be changed while the loop is running.

Top module: `dpll_core`

## Requirements
- R1: `xor_pd` equals the XOR of `ref_in` and `cmp_in`. A change on either input shows on `xor_pd` after the third rising `clk` edge, because there are two synchroniser stages plus one output register.
- R2: `edge_pd` goes to 1 after a rising edge of `ref_in` and to 0 after a rising edge of `cmp_in`, with the same three-edge latency as R1. Falling edges and steady levels leave it unchanged.
- R3: The K counter advances only in cycles where `k_en` is 1. It counts up when the synchronised `dir_in` is 0 and down when it is 1. `dir_in` takes effect two edges after it changes.
- R4: With a nonzero `mod_code`, the counter has `mod_code`+2 stages. An up count from all-ones to zero drives `carry_o` high for exactly the one cycle after that enable edge.
- R5: A down count from zero to all-ones drives `borrow_o` high for exactly one cycle, with the same timing as R4.
- R6: `mod_code` = 0 disables the counter. Enables then produce no carry or borrow, and the count value is held.
- R7: With `mod_code` = 1, a carry follows every 8th up-count enable starting from zero. With `mod_code` = 15, a carry follows the 131072nd enable.
- R8: If `mod_code` shrinks, the count is truncated to the new width at the next enable. A count that was full scale under code 15 produces a carry on the first up enable under code 1.
- R9: With no correction pending, `id_out` toggles at every rising edge where `id_en` is 1 and holds otherwise.
- R10: A carry that arrives before an `id_en` strobe makes `id_out` toggle at that strobe and toggle again on the following edge, which advances the output by one half-cycle.
- R11: A borrow that arrives before an `id_en` strobe suppresses the toggle at that strobe, which retards the output by one half-cycle.
- R12: A carry and a borrow that both arrive between the same two `id_en` strobes cancel, and the next strobe gives one normal toggle.
- R13: `rst` = 1 at a rising edge clears `xor_pd`, `edge_pd`, `carry_o`, `borrow_o`, `id_out` and the count.
- R14: `carry_o` and `borrow_o` are never high together, and neither stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| k_en | input | 1 | K counter enable strobe |
| id_en | input | 1 | I/D circuit enable strobe |
| ref_in | input | 1 | Reference signal (asynchronous) |
| cmp_in | input | 1 | Comparison signal from the external divider (asynchronous) |
| mod_code | input | 4 | K counter length code (0 disables the counter) |
| dir_in | input | 1 | Count direction: 0 counts up, 1 counts down |
| xor_pd | output | 1 | Exclusive-OR phase detector output |
| edge_pd | output | 1 | Edge-controlled phase detector output |
| carry_o | output | 1 | One-cycle pulse on an up-count wrap |
| borrow_o | output | 1 | One-cycle pulse on a down-count wrap |
| id_out | output | 1 | Corrected divided I/D output |

## Verification
The phase detectors are driven with a reference rise, a reference fall, and then comparison rises and falls. This separates the level-sensitive XOR from the edge-set, edge-clear detector, and it shows that falling edges leave the edge detector alone. The K counter is run under code 1 for a full 8-count wrap, under code 15 for the complete 131072-count span, and under code 0 with enables in both directions. This tells a correct stage count apart from an off-by-one length and a disable that leaks pulses. A full-scale value followed by a code reduction tests truncation. Finally, the I/D circuit is given four cases: no correction, a lone borrow, a lone carry, and a carry paired with a borrow. Each case produces a different toggle pattern around the strobe.

// File: rtl/dpll_pkg.sv
package dpll_pkg;
  // Correction the I/D circuit applies at its next strobe
  typedef enum logic [1:0] {
    CORR_NONE = 2'd0,
    CORR_ADV  = 2'd1,
    CORR_SKIP = 2'd2
  } corr_e;

  function automatic corr_e pick_corr(input logic inc, input logic dec);
    if (inc && !dec) return CORR_ADV;
    if (dec && !inc) return CORR_SKIP;
    return CORR_NONE;
  endfunction
endpackage

// File: rtl/dpll_sync.sv
module dpll_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dpll_phase_det.sv
module dpll_phase_det (
  input  logic clk,
  input  logic rst,
  input  logic ref_s,
  input  logic cmp_s,
  output logic xor_pd,
  output logic edge_pd
);
  logic ref_q, cmp_q;
  logic ref_rise, cmp_rise;

  assign ref_rise = ref_s & ~ref_q;
  assign cmp_rise = cmp_s & ~cmp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q   <= 1'b0;
      cmp_q   <= 1'b0;
      xor_pd  <= 1'b0;
      edge_pd <= 1'b0;
    end else begin
      ref_q  <= ref_s;
      cmp_q  <= cmp_s;
      xor_pd <= ref_s ^ cmp_s;
      // a comparison rise wins if both rise together
      if (cmp_rise)      edge_pd <= 1'b0;
      else if (ref_rise) edge_pd <= 1'b1;
    end
  end
endmodule

// File: rtl/dpll_kcounter.sv
module dpll_kcounter #(
  parameter int CODE_W    = 4,
  parameter int STAGE_OFS = 2,
  localparam int KW       = (1 << CODE_W) - 1 + STAGE_OFS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              down,
  input  logic [CODE_W-1:0] code,
  output logic              carry,
  output logic              borrow
);
  logic [KW-1:0] cnt, mask, cur;

  // active-stage mask: code + STAGE_OFS low bits set
  always_comb begin
    for (int i = 0; i < KW; i++)
      mask[i] = (i < (int'(code) + STAGE_OFS));
  end

  assign cur = cnt & mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      carry  <= 1'b0;
      borrow <= 1'b0;
    end else begin
      carry  <= 1'b0;
      borrow <= 1'b0;
      if (en && (code != '0)) begin
        if (!down) begin
          if (cur == mask) begin
            cnt   <= '0;
            carry <= 1'b1;
          end else begin
            cnt <= cur + 1'b1;
          end
        end else begin
          if (cur == '0) begin
            cnt    <= mask;
            borrow <= 1'b1;
          end else begin
            cnt <= cur - 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dpll_idcirc.sv
module dpll_idcirc
  import dpll_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic id_en,
  input  logic carry,
  input  logic borrow,
  output logic id_out
);
  logic  pend_inc, pend_dec, extra;
  corr_e corr;
  logic  tog;

  assign corr = pick_corr(pend_inc, pend_dec);
  assign tog  = extra ^ (id_en && (corr != CORR_SKIP));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_inc <= 1'b0;
      pend_dec <= 1'b0;
      extra    <= 1'b0;
      id_out   <= 1'b0;
    end else begin
      if (tog) id_out <= ~id_out;
      if (id_en) begin
        extra    <= (corr == CORR_ADV);
        pend_inc <= carry;
        pend_dec <= borrow;
      end else begin
        extra    <= 1'b0;
        pend_inc <= pend_inc | carry;
        pend_dec <= pend_dec | borrow;
      end
    end
  end
endmodule

// File: rtl/dpll_core.sv
module dpll_core #(
  parameter int CODE_W    = 4,
  parameter int STAGE_OFS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              k_en,
  input  logic              id_en,
  input  logic              ref_in,
  input  logic              cmp_in,
  input  logic [CODE_W-1:0] mod_code,
  input  logic              dir_in,
  output logic              xor_pd,
  output logic              edge_pd,
  output logic              carry_o,
  output logic              borrow_o,
  output logic              id_out
);
  localparam int NSYNC = 3;

  logic [NSYNC-1:0] raw_in, syn;

  assign raw_in = {dir_in, cmp_in, ref_in};

  dpll_sync #(.W(NSYNC)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(syn)
  );

  dpll_phase_det u_pd (
    .clk(clk), .rst(rst), .ref_s(syn[0]), .cmp_s(syn[1]),
    .xor_pd(xor_pd), .edge_pd(edge_pd)
  );

  dpll_kcounter #(.CODE_W(CODE_W), .STAGE_OFS(STAGE_OFS)) u_kcnt (
    .clk(clk), .rst(rst), .en(k_en), .down(syn[2]), .code(mod_code),
    .carry(carry_o), .borrow(borrow_o)
  );

  dpll_idcirc u_id (
    .clk(clk), .rst(rst), .id_en(id_en), .carry(carry_o), .borrow(borrow_o),
    .id_out(id_out)
  );
endmodule

// File: rtl/dpll_core_checker.sv
module dpll_core_checker #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              k_en,
  input logic              id_en,
  input logic              ref_in,
  input logic              cmp_in,
  input logic [CODE_W-1:0] mod_code,
  input logic              dir_in,
  input logic              xor_pd,
  input logic              edge_pd,
  input logic              carry_o,
  input logic              borrow_o,
  input logic              id_out
);
  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  // R13: outputs are clear in the cycle after a reset edge
  always @(posedge clk) begin
    if (rst_q)
      p_reset_clear_r13: assert (!xor_pd && !edge_pd && !carry_o && !borrow_o && !id_out);
  end

  p_pulse_excl_r14: assert property (@(posedge clk) disable iff (rst)
    !(carry_o && borrow_o));

  p_carry_single_r14: assert property (@(posedge clk) disable iff (rst)
    carry_o |=> !carry_o);

  p_borrow_single_r14: assert property (@(posedge clk) disable iff (rst)
    borrow_o |=> !borrow_o);

  p_no_enable_r3: assert property (@(posedge clk) disable iff (rst)
    !k_en |=> (!carry_o && !borrow_o));

  p_disabled_r6: assert property (@(posedge clk) disable iff (rst)
    (mod_code == '0) |=> (!carry_o && !borrow_o));

  p_id_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (!id_en && !$past(id_en)) |=> $stable(id_out));
endmodule

bind dpll_core dpll_core_checker #(.CODE_W(CODE_W)) u_chk (.*);

// File: tb/dpll_core_bench.sv
`timescale 1ns/1ps
module dpll_core_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic k_en = 1'b0, id_en = 1'b0, ref_in = 1'b0, cmp_in = 1'b0, dir_in = 1'b0;
  logic [3:0] mod_code = 4'd0;
  logic xor_pd, edge_pd, carry_o, borrow_o, id_out;

  always #4 clk = ~clk;

  dpll_core u_dpll_core (
    .clk(clk), .rst(rst), .k_en(k_en), .id_en(id_en), .ref_in(ref_in),
    .cmp_in(cmp_in), .mod_code(mod_code), .dir_in(dir_in),
    .xor_pd(xor_pd), .edge_pd(edge_pd), .carry_o(carry_o),
    .borrow_o(borrow_o), .id_out(id_out)
  );

  typedef struct {
    string req;
    int    sel;
    int    exp;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  int carry_seen = 0;
  int borrow_seen = 0;
  bit done = 0;
  event do_cmp, cmp_done;

  // pulse counters (sampled at posedge: values from the previous cycle)
  always @(posedge clk) begin
    if (!rst) begin
      if (carry_o)  carry_seen  = carry_seen + 1;
      if (borrow_o) borrow_seen = borrow_seen + 1;
    end
  end

  function automatic int get_out(input int sel);
    case (sel)
      0: return int'(xor_pd);
      1: return int'(edge_pd);
      2: return int'(carry_o);
      3: return int'(borrow_o);
      4: return int'(id_out);
      5: return carry_seen;
      6: return borrow_seen;
      default: return -1;
    endcase
  endfunction

  // monitor: pops expected items and compares them with the outputs
  initial begin
    forever begin
      @(do_cmp);
      while (q.size() > 0) begin
        item_t it;
        int act;
        it = q.pop_front();
        act = get_out(it.sel);
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s sel=%0d actual=%0d expected=%0d", it.req, it.sel, act, it.exp);
        end
      end
      -> cmp_done;
    end
  end

  task automatic expect_out(input string req, input int sel, input int exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic compare_now();
    -> do_cmp;
    @(cmp_done);
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
  endtask

  task automatic pulse_k();
    k_en = 1'b1;
    tick();
    k_en = 1'b0;
  endtask

  task automatic set_dir(input logic d);
    dir_in = d;
    tick(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int base_c, base_b, idv;
    @(negedge clk);
    do_reset();
    // R13: reset state
    for (int s = 0; s < 5; s++) expect_out("R13 reset", s, 0);
    compare_now();

    // R1/R2 phase detectors
    ref_in = 1'b1;
    tick(2);
    expect_out("R1 latency", 0, 0);
    compare_now();
    tick();
    expect_out("R1 ref high", 0, 1);
    expect_out("R2 ref rise sets", 1, 1);
    compare_now();
    ref_in = 1'b0;
    tick(3);
    expect_out("R1 both low", 0, 0);
    expect_out("R2 ref fall keeps", 1, 1);
    compare_now();
    cmp_in = 1'b1;
    tick(3);
    expect_out("R1 cmp high", 0, 1);
    expect_out("R2 cmp rise clears", 1, 0);
    compare_now();
    cmp_in = 1'b0;
    tick(3);
    expect_out("R2 cmp fall keeps", 1, 0);
    compare_now();

    // R13: reset mid-run
    ref_in = 1'b1;
    tick(4);
    ref_in = 1'b0;
    rst = 1'b1;
    tick();
    expect_out("R13 mid reset edge", 1, 0);
    expect_out("R13 mid reset xor", 0, 0);
    compare_now();
    tick(2);
    rst = 1'b0;
    tick(4);

    // R6: code 0 disables the counter
    mod_code = 4'd0;
    base_c = carry_seen; base_b = borrow_seen;
    set_dir(1'b0);
    k_en = 1'b1; tick(10); k_en = 1'b0;
    set_dir(1'b1);
    k_en = 1'b1; tick(10); k_en = 1'b0;
    tick();
    expect_out("R6 no carry", 5, base_c);
    expect_out("R6 no borrow", 6, base_b);
    compare_now();
    // count held at 0: first down enable under code 1 borrows (R5)
    mod_code = 4'd1;
    pulse_k();
    expect_out("R5 borrow pulse", 3, 1);
    expect_out("R14 no carry with borrow", 2, 0);
    compare_now();
    tick();
    expect_out("R5 borrow one cycle", 3, 0);
    compare_now();

    // R7/R4: code 1, 8 enables per carry
    do_reset();
    mod_code = 4'd1;
    set_dir(1'b0);
    base_c = carry_seen;
    k_en = 1'b1; tick(7); k_en = 1'b0;
    tick();
    expect_out("R7 no carry before 8", 5, base_c);
    compare_now();
    pulse_k();
    expect_out("R4 carry on wrap", 2, 1);
    compare_now();
    tick();
    expect_out("R4 carry one cycle", 2, 0);
    compare_now();

    // R3: enables absent -> no count (one up after wrap still no carry)
    tick(20);
    k_en = 1'b1; tick(7); k_en = 1'b0;
    tick();
    expect_out("R3 up count from 0", 2, 0);
    compare_now();
    // at 7: down one to 6, then up one -> 7, up one -> carry
    set_dir(1'b1);
    pulse_k();
    set_dir(1'b0);
    pulse_k();
    expect_out("R3 down then up", 2, 0);
    compare_now();
    pulse_k();
    expect_out("R3 carry at full", 2, 1);
    compare_now();

    // R8: truncation on code change
    do_reset();
    mod_code = 4'd15;
    set_dir(1'b1);
    pulse_k();
    expect_out("R5 borrow code15", 3, 1);
    compare_now();
    mod_code = 4'd1;
    set_dir(1'b0);
    pulse_k();
    expect_out("R8 truncated carry", 2, 1);
    compare_now();

    // R9..R12: I/D circuit
    do_reset();
    mod_code = 4'd1;
    idv = 0;
    for (int n = 0; n < 3; n++) begin
      id_en = 1'b1; tick(); id_en = 1'b0;
      idv = 1 - idv;
      expect_out("R9 toggle at strobe", 4, idv);
      compare_now();
      tick(3);
      expect_out("R9 hold between", 4, idv);
      compare_now();
    end
    // lone borrow
    set_dir(1'b1);
    pulse_k();
    tick();
    id_en = 1'b1; tick(); id_en = 1'b0;
    expect_out("R11 borrow skips", 4, idv);
    compare_now();
    tick(3);
    // lone carry (count 7 -> 0)
    set_dir(1'b0);
    pulse_k();
    tick();
    id_en = 1'b1; tick(); id_en = 1'b0;
    expect_out("R10 toggle at strobe", 4, 1 - idv);
    compare_now();
    tick();
    expect_out("R10 extra toggle", 4, idv);
    compare_now();
    tick(3);
    // carry plus borrow before one strobe
    set_dir(1'b1);
    pulse_k();
    set_dir(1'b0);
    pulse_k();
    tick();
    id_en = 1'b1; tick(); id_en = 1'b0;
    idv = 1 - idv;
    expect_out("R12 cancel toggle", 4, idv);
    compare_now();
    tick();
    expect_out("R12 no extra", 4, idv);
    compare_now();
    tick(3);

    // R7: code 15 full span
    do_reset();
    mod_code = 4'd15;
    set_dir(1'b0);
    base_c = carry_seen;
    k_en = 1'b1; tick(131071); k_en = 1'b0;
    tick();
    expect_out("R7 no early carry code15", 5, base_c);
    expect_out("R7 no carry now", 2, 0);
    compare_now();
    pulse_k();
    expect_out("R7 carry at 131072", 2, 1);
    compare_now();
    tick();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule